// File: doc/BRIEF.md
# Guarded-Refresh Watchdog Timer

This block is a free-running supervision counter for a small microcontroller. Software starts it once with a single start write. After that it counts up by one on every machine-cycle enable, and nothing but the chip's external reset can stop it. If the count reaches the trip value, three below the top of the counter range, the block raises an internal reset request. That request lasts a fixed number of machine cycles. Afterwards the counter carries on from the reload value without any new start command.

Refreshing the counter takes two writes in consecutive machine cycles. The first write sets an arm flag. The second write sets the start bit. Only that pair loads the counter from the reload input. The arm flag clears itself if no confirm arrives. A start write on its own, or a confirm that comes one cycle too late, leaves the count unchanged.

The running flag stays set through a watchdog-caused reset and is cleared only by the external reset. Software can therefore read it to tell the two kinds of reset apart.

Top module: `wdog_guarded`

## Requirements
- R1: While `rst_n` is low, `count_q` is 0, and `armed_q`, `running_q` and `wd_reset_req` are all 0.
- R2: While `running_q` is 0, `count_q` does not change except through a refresh. While it is 1, `count_q` rises by exactly 1 on each clock edge with `mc_en` high and holds on edges with `mc_en` low.
- R3: A `start_set` strobe sets `running_q`. A start strobe that is not a valid refresh never reloads `count_q`.
- R4: Once set, `running_q` stays 1 until `rst_n` goes low. No strobe pattern and no watchdog reset clears it.
- R5: An `arm_set` strobe sets `armed_q`. If no confirm follows, `armed_q` returns to 0 on the second machine-cycle edge after it was set.
- R6: An `arm_set` on one machine-cycle edge followed by a `start_set` on the next machine-cycle edge loads `count_q` from `reload_val` and clears `armed_q`. The load replaces that cycle's increment.
- R7: A `start_set` that comes two machine cycles after `arm_set` is a plain start write: the counter increments and no reload happens.
- R8: When `count_q` equals 16'hFFFC on a machine-cycle edge, `wd_reset_req` rises on that edge and stays high for exactly 4 machine cycles.
- R9: A trip loads `count_q` from `reload_val`. The count holds through the request, then resumes incrementing with `running_q` still 1.
- R10: Starting from a count of 0, the trip value is reached after exactly 65532 machine cycles.
- R11: Strobes presented on edges where `mc_en` is low have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | External reset, active low |
| mc_en | input | 1 | Machine-cycle enable |
| arm_set | input | 1 | Single-cycle strobe that sets the arm flag |
| start_set | input | 1 | Single-cycle strobe that starts or confirms a refresh |
| reload_val | input | CNT_W | Value loaded on refresh and on trip |
| count_q | output | CNT_W | Current counter value |
| armed_q | output | 1 | Arm flag |
| running_q | output | 1 | Running/status flag |
| wd_reset_req | output | 1 | Internal reset request |

## Verification
The bench uses the defaults: a 16-bit counter and a 4-cycle reset request. With these settings the full 65532-cycle timeout from a zero count can be measured exactly, within the cycle budget. Trip and post-trip behaviour are also reached quickly by refreshing to a reload value just below the trip point. The enable input is held low for some stretches to show that counting and strobe capture both depend on it.

// File: rtl/wdog_guarded.sv
module wdog_guarded #(
  parameter int CNT_W      = 16,
  parameter int RST_CYCLES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mc_en,
  input  logic             arm_set,
  input  logic             start_set,
  input  logic [CNT_W-1:0] reload_val,
  output logic [CNT_W-1:0] count_q,
  output logic             armed_q,
  output logic             running_q,
  output logic             wd_reset_req
);
  localparam logic [CNT_W-1:0] TRIP_VAL = {CNT_W{1'b1}} - CNT_W'(3);
  localparam int RW = $clog2(RST_CYCLES + 1);

  logic          arm_age;
  logic [RW-1:0] rst_left;

  wire tick    = mc_en && !wd_reset_req;
  wire confirm = tick && start_set && armed_q && !arm_age;
  wire trip    = tick && running_q && (count_q == TRIP_VAL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q      <= '0;
      armed_q      <= 1'b0;
      arm_age      <= 1'b0;
      running_q    <= 1'b0;
      wd_reset_req <= 1'b0;
      rst_left     <= '0;
    end else if (mc_en) begin
      if (tick && start_set) running_q <= 1'b1;

      if (wd_reset_req || confirm) begin
        armed_q <= 1'b0;
      end else if (arm_set) begin
        armed_q <= 1'b1;
        arm_age <= 1'b0;
      end else if (armed_q) begin
        if (arm_age) armed_q <= 1'b0;
        arm_age <= 1'b1;
      end

      if (trip || confirm)        count_q <= reload_val;
      else if (tick && running_q) count_q <= count_q + CNT_W'(1);

      if (trip) begin
        wd_reset_req <= 1'b1;
        rst_left     <= RW'(RST_CYCLES - 1);
      end else if (wd_reset_req) begin
        if (rst_left == '0) wd_reset_req <= 1'b0;
        else                rst_left     <= rst_left - RW'(1);
      end
    end
  end

  // R4
  run_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    running_q |=> running_q);

  // R2
  count_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mc_en |=> $stable(count_q));

  // R8
  trip_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mc_en && running_q && !wd_reset_req && count_q == TRIP_VAL) |=> wd_reset_req);

  // R9
  req_keeps_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wd_reset_req |-> running_q);

  // R5
  arm_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mc_en && armed_q && arm_age && !arm_set) |=> !armed_q);

  // R11
  arm_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mc_en && !armed_q) |=> !armed_q);
endmodule

// File: tb/test_wdog_guarded.sv
module test_wdog_guarded;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         mc_en = 1'b0;
  logic         arm_set = 1'b0;
  logic         start_set = 1'b0;
  logic [W-1:0] reload_val = '0;
  logic [W-1:0] count_q;
  logic         armed_q, running_q, wd_reset_req;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdog_guarded i_wdog_guarded (
    .clk(clk), .rst_n(rst_n), .mc_en(mc_en), .arm_set(arm_set),
    .start_set(start_set), .reload_val(reload_val), .count_q(count_q),
    .armed_q(armed_q), .running_q(running_q), .wd_reset_req(wd_reset_req)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input logic a, input logic s, input logic en = 1'b1);
    arm_set = a; start_set = s; mc_en = en;
    @(negedge clk);
    arm_set = 1'b0; start_set = 1'b0; mc_en = 1'b1;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    @(negedge clk); @(negedge clk);
    chk("R1 count", count_q, 0);
    chk("R1 flags", {armed_q, running_q, wd_reset_req}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    step(0, 0); step(0, 0);
    chk("R2 idle count", count_q, 0);
  endtask

  task automatic t_start();
    step(0, 1);
    chk("R3 running", running_q, 1);
    chk("R3 count at start", count_q, 0);
    for (int i = 0; i < 4; i++) step(0, 0);
    chk("R2 counting", count_q, 4);
    step(0, 1);
    chk("R3 no reload", count_q, 5);
    step(1, 1, 1'b0); step(0, 0, 1'b0); step(0, 0, 1'b0);
    chk("R11 count held", count_q, 5);
    chk("R11 arm ignored", armed_q, 0);
  endtask

  task automatic t_refresh();
    reload_val = 16'h1234;
    step(1, 0);
    chk("R5 armed", armed_q, 1);
    chk("R2 count", count_q, 6);
    step(0, 1);
    chk("R6 reload", count_q, 16'h1234);
    chk("R6 arm cleared", armed_q, 0);
    step(0, 0);
    chk("R6 resume", count_q, 16'h1235);
  endtask

  task automatic t_expire();
    step(1, 0);
    step(0, 0);
    chk("R5 still armed", armed_q, 1);
    step(0, 0);
    chk("R5 expired", armed_q, 0);
    chk("R5 count", count_q, 16'h1238);
    step(1, 0); step(0, 0); step(0, 1);
    chk("R7 late confirm", count_q, 16'h123B);
    chk("R4 running", running_q, 1);
  endtask

  task automatic t_trip();
    reload_val = 16'hFFF0;
    step(1, 0); step(0, 1);
    chk("R6 near trip", count_q, 16'hFFF0);
    reload_val = 16'h0100;
    for (int i = 0; i < 12; i++) step(0, 0);
    chk("R8 at trip", count_q, 16'hFFFC);
    chk("R8 req low", wd_reset_req, 0);
    for (int i = 0; i < 4; i++) begin
      step(0, 0);
      chk("R8 req high", wd_reset_req, 1);
      chk("R9 count held", count_q, 16'h0100);
    end
    step(0, 0);
    chk("R8 req ended", wd_reset_req, 0);
    step(0, 0);
    chk("R9 resume", count_q, 16'h0101);
    chk("R4 running after trip", running_q, 1);
  endtask

  task automatic t_full();
    reload_val = 16'h0000;
    step(1, 0); step(0, 1);
    chk("R10 cleared", count_q, 0);
    for (int i = 0; i < 65532; i++) step(0, 0);
    chk("R10 trip value", count_q, 16'hFFFC);
    chk("R10 no req yet", wd_reset_req, 0);
    step(0, 0);
    chk("R10 req", wd_reset_req, 1);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_start();
    t_refresh();
    t_expire();
    t_trip();
    t_full();
    t_reset();
    chk("R1 running cleared", running_q, 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule